// File: doc/BRIEF.md
# Video RAM Bank Fill Engine

This block clears or fills a whole video RAM bank with one byte value, so that the host does not have to write every location itself. The host programs a small parameter RAM: byte 0 names the bank to fill and byte 1 holds the value. It then writes a control register with the start bit set. From the next cycle on, the engine writes one byte per clock into the chosen bank and raises a busy flag. The host polls that flag until it reads 0.

The same control write also carries a ROM bank index and a video RAM write-enable flag. The block latches both and drives them out. Host writes to video RAM pass through the block onto the write port of each bank. They are gated by the write-enable flag. While a fill runs, the bank being filled belongs to the engine. Host writes to that bank are then discarded, and host writes to the other bank still go through.

Top module: `vram_fill_engine`

## Requirements
- R1: After reset, `busy` is 0, `rom_bank` is 0, `vram_wr_en` is 0 and no bank write strobe is active.
- R2: A control write latches `ctl_wdata[3:0]` into `rom_bank` and `ctl_wdata[7]` into `vram_wr_en`. Both are visible on the cycle after the write.
- R3: A control write with `ctl_wdata[6]` = 1 while idle starts a fill. `busy` reads 1 from the next cycle and stays 1 for exactly 8192 cycles.
- R4: During a fill, the target bank's port writes on every cycle. Its address runs 0, 1, ... 0x1FFF, one step per clock, and its data is the fill value. The other bank receives no fill write.
- R5: The target bank is bit 0 of parameter byte 0. Bits 7:1 of that byte have no effect.
- R6: The fill value is parameter byte 1. Bank and value are captured when the fill starts, so later parameter writes do not alter a running fill.
- R7: A start request that arrives while busy is ignored: the address sequence and the end time do not change. The same write still updates `rom_bank` and `vram_wr_en`.
- R8: When not filling, a host write with `vram_wr_en` = 1 appears on the selected bank's port with its address and data in the same cycle. With `vram_wr_en` = 0 it is dropped.
- R9: During a fill, a host write to the target bank is dropped. The engine's address and data stay on that port.
- R10: A parameter RAM write is read back on `prm_rdata` at that address from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: [3:0] ROM bank, [6] start fill, [7] write enable |
| prm_we | input | 1 | Parameter RAM write strobe |
| prm_addr | input | 4 | Parameter RAM address for write and read |
| prm_wdata | input | 8 | Parameter RAM write data |
| prm_rdata | output | 8 | Parameter RAM read data at `prm_addr` |
| host_vwe | input | 1 | Host video RAM write strobe |
| host_vbank | input | 1 | Host write bank select |
| host_vaddr | input | 13 | Host write address |
| host_vdata | input | 8 | Host write data |
| rom_bank | output | 4 | Latched ROM bank index |
| vram_wr_en | output | 1 | Latched video RAM write-enable flag |
| busy | output | 1 | Fill in progress |
| vram_we | output | 2 | Write strobe per bank |
| vram_addr | output | 2x13 | Write address per bank |
| vram_data | output | 2x8 | Write data per bank |

## Verification
A wrong count or a lost capture register shows at once on the bank ports. A skipped or repeated address, a changed value or a write to the wrong bank appears on the first faulty cycle, because every fill cycle is compared with its expected address and data. A sequencer that restarts on a second trigger, or that ends one cycle early or late, becomes visible when `busy` falls, at most 8192 cycles later. A priority error in the port multiplexer shows in the same cycle as the colliding host write.

// File: rtl/vfe_pkg.sv
package vfe_pkg;
  localparam int unsigned CTL_START_BIT = 6;
  localparam int unsigned CTL_WREN_BIT  = 7;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/vfe_ctl_regs.sv
module vfe_ctl_regs
  import vfe_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ROMSEL_W = 4,
  parameter int unsigned PRM_AW   = 4,
  parameter int unsigned SEL_W    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [DATA_W-1:0]   ctl_wdata,
  input  logic                prm_we,
  input  logic [PRM_AW-1:0]   prm_addr,
  input  logic [DATA_W-1:0]   prm_wdata,
  output logic [DATA_W-1:0]   prm_rdata,
  output logic [ROMSEL_W-1:0] rom_bank,
  output logic                vwr_en,
  output logic                start_req,
  output logic [SEL_W-1:0]    prm_tgt,
  output logic [DATA_W-1:0]   prm_val
);
  localparam int unsigned PRM_DEPTH = 1 << PRM_AW;

  logic [ROMSEL_W-1:0] rom_bank_n;
  logic                vwr_en_n;
  logic [DATA_W-1:0]   prm_mem [PRM_DEPTH];
  logic                unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_wdata;

  always_comb begin
    rom_bank_n = rom_bank;
    vwr_en_n   = vwr_en;
    if (ctl_we) begin
      rom_bank_n = ctl_wdata[ROMSEL_W-1:0];
      vwr_en_n   = ctl_wdata[CTL_WREN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= '0;
      vwr_en   <= 1'b0;
    end else begin
      rom_bank <= rom_bank_n;
      vwr_en   <= vwr_en_n;
    end
  end

  for (genvar g = 0; g < PRM_DEPTH; g++) begin : g_prm
    logic wr_hit;
    assign wr_hit = prm_we && (prm_addr == PRM_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prm_mem[g] <= '0;
      end else if (wr_hit) begin
        prm_mem[g] <= prm_wdata;
      end
    end
  end

  assign prm_rdata = prm_mem[prm_addr];
  assign start_req = ctl_we && ctl_wdata[CTL_START_BIT];
  assign prm_tgt   = prm_mem[0][SEL_W-1:0];
  assign prm_val   = prm_mem[1];
endmodule

// File: rtl/vfe_fill_seq.sv
module vfe_fill_seq
  import vfe_pkg::*;
#(
  parameter int unsigned AW     = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [SEL_W-1:0]  tgt_in,
  input  logic [DATA_W-1:0] val_in,
  output logic              busy,
  output logic [AW-1:0]     fill_cnt,
  output logic [SEL_W-1:0]  fill_bank,
  output logic [DATA_W-1:0] fill_val
);
  seq_state_e        state, state_n;
  logic [AW-1:0]     cnt_n;
  logic [SEL_W-1:0]  bank_n;
  logic [DATA_W-1:0] val_n;
  logic              last_addr;

  assign last_addr = &fill_cnt;

  always_comb begin
    state_n = state;
    cnt_n   = fill_cnt;
    bank_n  = fill_bank;
    val_n   = fill_val;
    unique case (state)
      SEQ_IDLE: begin
        if (start_req) begin
          state_n = SEQ_RUN;
          cnt_n   = '0;
          bank_n  = tgt_in;
          val_n   = val_in;
        end
      end
      SEQ_RUN: begin
        cnt_n = fill_cnt + 1'b1;
        if (last_addr) begin
          state_n = SEQ_IDLE;
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      fill_cnt  <= '0;
      fill_bank <= '0;
      fill_val  <= '0;
    end else begin
      state     <= state_n;
      fill_cnt  <= cnt_n;
      fill_bank <= bank_n;
      fill_val  <= val_n;
    end
  end

  assign busy = (state == SEQ_RUN);
endmodule

// File: rtl/vfe_port_mux.sv
module vfe_port_mux #(
  parameter int unsigned AW        = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned SEL_W     = 1
) (
  input  logic                                busy,
  input  logic [AW-1:0]                       fill_cnt,
  input  logic [SEL_W-1:0]                    fill_bank,
  input  logic [DATA_W-1:0]                   fill_val,
  input  logic                                vwr_en,
  input  logic                                host_vwe,
  input  logic [SEL_W-1:0]                    host_vbank,
  input  logic [AW-1:0]                       host_vaddr,
  input  logic [DATA_W-1:0]                   host_vdata,
  output logic [NUM_BANKS-1:0]                vram_we,
  output logic [NUM_BANKS-1:0][AW-1:0]        vram_addr,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]    vram_data
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic fill_hit;
    logic host_hit;
    assign fill_hit     = busy && (fill_bank == SEL_W'(b));
    assign host_hit     = host_vwe && vwr_en && (host_vbank == SEL_W'(b));
    assign vram_we[b]   = fill_hit || host_hit;
    assign vram_addr[b] = fill_hit ? fill_cnt : host_vaddr;
    assign vram_data[b] = fill_hit ? fill_val : host_vdata;
  end
endmodule

// File: rtl/vram_fill_engine.sv
module vram_fill_engine #(
  parameter int unsigned BANK_AW   = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ROMSEL_W  = 4,
  parameter int unsigned PRM_AW    = 4,
  localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ctl_we,
  input  logic [DATA_W-1:0]                ctl_wdata,
  input  logic                             prm_we,
  input  logic [PRM_AW-1:0]                prm_addr,
  input  logic [DATA_W-1:0]                prm_wdata,
  output logic [DATA_W-1:0]                prm_rdata,
  input  logic                             host_vwe,
  input  logic [SEL_W-1:0]                 host_vbank,
  input  logic [BANK_AW-1:0]               host_vaddr,
  input  logic [DATA_W-1:0]                host_vdata,
  output logic [ROMSEL_W-1:0]              rom_bank,
  output logic                             vram_wr_en,
  output logic                             busy,
  output logic [NUM_BANKS-1:0]             vram_we,
  output logic [NUM_BANKS-1:0][BANK_AW-1:0] vram_addr,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]  vram_data
);
  logic               start_req;
  logic [SEL_W-1:0]   prm_tgt;
  logic [DATA_W-1:0]  prm_val;
  logic [BANK_AW-1:0] fill_cnt;
  logic [SEL_W-1:0]   fill_bank;
  logic [DATA_W-1:0]  fill_val;

  vfe_ctl_regs #(
    .DATA_W(DATA_W), .ROMSEL_W(ROMSEL_W), .PRM_AW(PRM_AW), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prm_we(prm_we), .prm_addr(prm_addr), .prm_wdata(prm_wdata),
    .prm_rdata(prm_rdata),
    .rom_bank(rom_bank), .vwr_en(vram_wr_en),
    .start_req(start_req), .prm_tgt(prm_tgt), .prm_val(prm_val)
  );

  vfe_fill_seq #(
    .AW(BANK_AW), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .tgt_in(prm_tgt), .val_in(prm_val),
    .busy(busy), .fill_cnt(fill_cnt), .fill_bank(fill_bank), .fill_val(fill_val)
  );

  vfe_port_mux #(
    .AW(BANK_AW), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)
  ) u_mux (
    .busy(busy), .fill_cnt(fill_cnt), .fill_bank(fill_bank), .fill_val(fill_val),
    .vwr_en(vram_wr_en),
    .host_vwe(host_vwe), .host_vbank(host_vbank),
    .host_vaddr(host_vaddr), .host_vdata(host_vdata),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data)
  );
endmodule

// File: rtl/vfe_checker.sv
module vfe_checker
  import vfe_pkg::*;
#(
  parameter int unsigned AW        = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ROMSEL_W  = 4,
  parameter int unsigned SEL_W     = 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ctl_we,
  input logic [DATA_W-1:0]                ctl_wdata,
  input logic                             host_vwe,
  input logic [ROMSEL_W-1:0]              rom_bank,
  input logic                             vram_wr_en,
  input logic                             busy,
  input logic [NUM_BANKS-1:0]             vram_we,
  input logic [NUM_BANKS-1:0][AW-1:0]     vram_addr,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] vram_data,
  input logic [AW-1:0]                    fill_cnt,
  input logic [SEL_W-1:0]                 fill_bank,
  input logic [DATA_W-1:0]                fill_val
);
  assert_ctl_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (rom_bank == $past(ctl_wdata[ROMSEL_W-1:0]))
               && (vram_wr_en == $past(ctl_wdata[CTL_WREN_BIT])));

  assert_fill_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CTL_START_BIT] && !busy) |=> (busy && (fill_cnt == '0)));

  assert_fill_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (&$past(fill_cnt)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (fill_cnt == AW'($past(fill_cnt) + 1'b1)));

  assert_job_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fill_bank) && $stable(fill_val)));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we && ctl_wdata[CTL_START_BIT])
      |=> (!busy || (fill_cnt == AW'($past(fill_cnt) + 1'b1))));

  assert_host_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_vwe && !vram_wr_en && !busy) |-> (vram_we == '0));

  assert_fill_owns_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vram_we[fill_bank] && (vram_addr[fill_bank] == fill_cnt)
              && (vram_data[fill_bank] == fill_val)));
endmodule

bind vram_fill_engine vfe_checker #(
  .AW(BANK_AW), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
  .ROMSEL_W(ROMSEL_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .host_vwe(host_vwe), .rom_bank(rom_bank), .vram_wr_en(vram_wr_en),
  .busy(busy), .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data),
  .fill_cnt(fill_cnt), .fill_bank(fill_bank), .fill_val(fill_val)
);

// File: tb/sim_vram_fill_engine.sv
`timescale 1ns/1ps
module sim_vram_fill_engine;
  logic            clk = 1'b0;
  logic            rst_n;
  logic            ctl_we;
  logic [7:0]      ctl_wdata;
  logic            prm_we;
  logic [3:0]      prm_addr;
  logic [7:0]      prm_wdata;
  logic [7:0]      prm_rdata;
  logic            host_vwe;
  logic            host_vbank;
  logic [12:0]     host_vaddr;
  logic [7:0]      host_vdata;
  logic [3:0]      rom_bank;
  logic            vram_wr_en;
  logic            busy;
  logic [1:0]      vram_we;
  logic [1:0][12:0] vram_addr;
  logic [1:0][7:0]  vram_data;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  vram_fill_engine u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prm_we(prm_we), .prm_addr(prm_addr), .prm_wdata(prm_wdata), .prm_rdata(prm_rdata),
    .host_vwe(host_vwe), .host_vbank(host_vbank), .host_vaddr(host_vaddr),
    .host_vdata(host_vdata), .rom_bank(rom_bank), .vram_wr_en(vram_wr_en),
    .busy(busy), .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prm_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    prm_we = 1'b1; prm_addr = a; prm_wdata = d;
    @(negedge clk);
    prm_we = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rom_bank == 4'h0, "R1 rom_bank", rom_bank, 0);
    chk(vram_wr_en == 1'b0, "R1 vram_wr_en", vram_wr_en, 0);
    chk(vram_we == 2'b00, "R1 vram_we", vram_we, 0);
  endtask

  task automatic test_prm();
    prm_write(4'd5, 8'h3C);
    prm_addr = 4'd5; #1;
    chk(prm_rdata == 8'h3C, "R10 readback byte5", prm_rdata, 8'h3C);
    prm_write(4'd1, 8'h77);
    prm_addr = 4'd1; #1;
    chk(prm_rdata == 8'h77, "R10 readback byte1", prm_rdata, 8'h77);
  endtask

  task automatic test_ctl();
    ctl_write(8'h8B);
    chk(rom_bank == 4'hB, "R2 rom_bank", rom_bank, 4'hB);
    chk(vram_wr_en == 1'b1, "R2 vram_wr_en", vram_wr_en, 1);
    chk(busy == 1'b0, "R2 no start without bit6", busy, 0);
  endtask

  task automatic test_host();
    ctl_write(8'h81);
    host_vwe = 1'b1; host_vbank = 1'b1; host_vaddr = 13'h0ABC; host_vdata = 8'h42;
    #1;
    chk(vram_we == 2'b10, "R8 host pass strobe", vram_we, 2'b10);
    chk(vram_addr[1] == 13'h0ABC && vram_data[1] == 8'h42, "R8 host pass addr/data",
        {vram_addr[1], vram_data[1]}, {13'h0ABC, 8'h42});
    host_vwe = 1'b0;
    ctl_write(8'h01);
    host_vwe = 1'b1; host_vbank = 1'b0;
    #1;
    chk(vram_we == 2'b00, "R8 host dropped when disabled", vram_we, 0);
    host_vwe = 1'b0;
  endtask

  // mode 0 plain, 1 parameter change mid-fill, 2 retrigger mid-fill, 3 host collision
  task automatic do_fill(input logic [7:0] b0, input logic [7:0] val, input int mode,
                         input string tag);
    bit   bad = 1'b0;
    logic tgt = b0[0];
    logic oth = ~b0[0];
    prm_write(4'd0, b0);
    prm_write(4'd1, val);
    ctl_write(8'hC2);
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    for (int i = 0; i < 8192; i++) begin
      if (!bad) begin
        if (!(vram_we[tgt] && vram_addr[tgt] == 13'(i) && vram_data[tgt] == val
              && busy)) begin
          bad = 1'b1;
          chk(1'b0, {tag, " R4 fill write"}, {vram_we[tgt], vram_addr[tgt], vram_data[tgt]},
              {1'b1, 13'(i), val});
        end else if (mode != 3 && vram_we[oth]) begin
          bad = 1'b1;
          chk(1'b0, {tag, " R5 other bank untouched"}, vram_we[oth], 0);
        end
      end
      if (mode == 1) begin
        if (i == 100) begin prm_we = 1'b1; prm_addr = 4'd0; prm_wdata = {7'h0, oth}; end
        if (i == 101) begin prm_addr = 4'd1; prm_wdata = ~val; end
        if (i == 102) prm_we = 1'b0;
      end
      if (mode == 2) begin
        if (i == 200) begin ctl_we = 1'b1; ctl_wdata = 8'hC5; end
        if (i == 201) begin
          ctl_we = 1'b0;
          chk(rom_bank == 4'h5, "R7 rom_bank updates while busy", rom_bank, 5);
        end
      end
      if (mode == 3) begin
        if (i == 300) begin
          host_vwe = 1'b1; host_vbank = tgt; host_vaddr = 13'h0005; host_vdata = 8'hAA;
          #1;
          chk(vram_addr[tgt] == 13'd300 && vram_data[tgt] == val, "R9 host write to target dropped",
              {vram_addr[tgt], vram_data[tgt]}, {13'd300, val});
        end
        if (i == 301) begin
          host_vbank = oth;
          #1;
          chk(vram_we[oth] && vram_addr[oth] == 13'h0005 && vram_data[oth] == 8'hAA,
              "R8 host write to other bank during fill",
              {vram_we[oth], vram_addr[oth], vram_data[oth]}, {1'b1, 13'h0005, 8'hAA});
        end
        if (i == 302) host_vwe = 1'b0;
      end
      @(negedge clk);
    end
    if (!bad) chk(1'b1, {tag, " R4 fill sequence"}, 0, 0);
    chk(busy == 1'b0, {tag, " R3 busy drops after 8192 cycles"}, busy, 0);
    chk(vram_we == 2'b00, {tag, " R3 no write after fill"}, vram_we, 0);
    if (mode == 1) begin
      prm_addr = 4'd1; #1;
      chk(prm_rdata == ~val, "R6 new parameter stored", prm_rdata, ~val);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; prm_we = 1'b0; prm_addr = '0;
    prm_wdata = '0; host_vwe = 1'b0; host_vbank = 1'b0; host_vaddr = '0; host_vdata = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_prm();
    test_ctl();
    test_host();
    do_fill(8'hFE, 8'h5A, 0, "R5 bank0 upper bits set");
    do_fill(8'h03, 8'hC3, 1, "R6 bank1 param change");
    do_fill(8'h00, 8'h0F, 2, "R7 retrigger");
    do_fill(8'h01, 8'h99, 3, "R9 collision");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule